// File: doc/BRIEF.md
# Modulo Context Sequencer with Fire Control

This block sits beside one tile of a coarse-grained reconfigurable array and feeds it its configuration. A host first writes per-cycle configuration words (contexts) into a small slot memory. After a start pulse the block steps through the slots one per clock. It wraps back to slot 0 after II slots, where II is the initiation interval given at start. The current context word is driven to the tile, where each functional or routing unit decodes its own fields: input selects, ALU opcode and register-file controls.

Each attached unit also receives a fire enable from the block, and it acts only in cycles where that enable is high. The schedule for a unit is a start cycle and an iteration count. The enable is high from the start cycle for iteration-count times II cycles, counted on a global cycle counter that begins at zero with the run. When every unit's window has closed, the run stops and a done flag is raised.

Contexts are written through a valid/ready load port. That port never applies back-pressure: `ld_ready` is always high and every beat with `ld_valid` is consumed. A beat is stored while the block is idle. A beat that arrives during a run is dropped and raises an error flag.

Top module: `mod_ctx_seq`

## Requirements
- R1: `ld_ready` is always 1. A beat with `ld_valid` high while not running writes `ld_data` into slot `ld_addr`, and the new word is visible from the next cycle.
- R2: A start pulse captures `ii_m1` and the per-unit schedule, clears the slot and cycle counters and clears `done`. From the next cycle `running` is 1 and `ctx_slot` is 0. A start pulse during a run restarts it the same way.
- R3: While running, `ctx_slot` advances by one per cycle and returns to 0 after slot II-1, where II = `ii_m1` + 1 (range 1 to 16).
- R4: `ctx_out` always equals the stored word of slot `ctx_slot`.
- R5: Let k be the count of cycles since the start pulse, with k = 0 in the first cycle after the start edge. Unit u has start S_u (field u of `sched_start`, CYC_W bits) and count N_u (field u of `sched_iters`, ITER_W bits). `fire[u]` is 1 exactly when S_u <= k < S_u + N_u*II. A count of 0 means the unit never fires.
- R6: Let E be the largest S_u + N_u*II. `running` stays 1 through cycle k = E. In the following cycle `running` is 0 and `done` is 1, and `done` stays 1 until the next start pulse. `fire` is all zero whenever `running` is 0.
- R7: A load beat while running leaves the slot memory unchanged and sets `load_err` from the next cycle. `load_err` holds until a start pulse or reset clears it.
- R8: After reset the block is idle. `running`, `done`, `load_err` and `fire` are 0, `ctx_slot` is 0 and every slot holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that starts (or restarts) a run |
| ii_m1 | input | AW | Initiation interval minus one, captured at start |
| sched_start | input | NUM_UNITS*CYC_W | Per-unit first fire cycle, unit u in bits [u*CYC_W +: CYC_W] |
| sched_iters | input | NUM_UNITS*ITER_W | Per-unit iteration count, unit u in bits [u*ITER_W +: ITER_W] |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Load beat ready, constant 1 |
| ld_addr | input | AW | Slot written by the load beat |
| ld_data | input | CTX_W | Context word of the load beat |
| ctx_out | output | CTX_W | Context word of the current slot |
| ctx_slot | output | AW | Current slot index |
| fire | output | NUM_UNITS | Per-unit fire enables |
| running | output | 1 | A run is in progress |
| done | output | 1 | The last run ended with all windows closed |
| load_err | output | 1 | A load beat arrived while running |

## Verification
Counters, `running` and `done` are registered, so a start pulse sampled at one edge gives k = 0 in the cycle right after it. `fire` and `ctx_out` are combinational from the registered counters and change in that same cycle. A load beat shows up in `ctx_out` or in `load_err` one cycle after its edge. `done` rises one cycle after cycle k = E. The bench drives and samples on the falling edge and keeps its own k counter from the start edge. For every sampled cycle it compares slot, context, fire and state against values computed from k, II and the schedule.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic {RUN_IDLE = 1'b0, RUN_ACTIVE = 1'b1} run_e;

  // Number of cycle-counter bits that cover start + iterations * II with headroom.
  function automatic int cnt_bits(input int cyc_w, input int iter_w, input int aw);
    return ((cyc_w > iter_w + aw + 1) ? cyc_w : iter_w + aw + 1) + 1;
  endfunction
endpackage

// File: rtl/mcs_ctx_store.sv
module mcs_ctx_store #(
  parameter int SLOTS = 16,
  parameter int CTX_W = 32,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CTX_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [CTX_W-1:0] rd_data
);
  logic [CTX_W-1:0] mem_q [SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/mcs_run_ctrl.sv
module mcs_run_ctrl
  import mcs_pkg::*;
#(
  parameter int AW    = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    ii_m1,
  input  logic             all_expired,
  output logic             running,
  output logic             done,
  output logic [AW-1:0]    slot,
  output logic [CNT_W-1:0] cyc,
  output logic [AW-1:0]    ii_q
);
  run_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RUN_IDLE;
      done    <= 1'b0;
      slot    <= '0;
      cyc     <= '0;
      ii_q    <= '0;
    end else if (start) begin
      state_q <= RUN_ACTIVE;
      done    <= 1'b0;
      slot    <= '0;
      cyc     <= '0;
      ii_q    <= ii_m1;
    end else if (state_q == RUN_ACTIVE) begin
      if (all_expired) begin
        state_q <= RUN_IDLE;
        done    <= 1'b1;
        slot    <= '0;
      end else begin
        slot <= (slot == ii_q) ? '0 : slot + 1'b1;
        if (cyc != '1) cyc <= cyc + 1'b1;
      end
    end
  end

  assign running = (state_q == RUN_ACTIVE);
endmodule

// File: rtl/mcs_fire_unit.sv
module mcs_fire_unit #(
  parameter int AW     = 4,
  parameter int CYC_W  = 8,
  parameter int ITER_W = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     ii_m1,
  input  logic [CYC_W-1:0]  cfg_start,
  input  logic [ITER_W-1:0] cfg_iters,
  input  logic              running,
  input  logic [CNT_W-1:0]  cyc,
  output logic              fire,
  output logic              expired
);
  logic [AW:0]      ii_len;
  logic [CNT_W-1:0] win_lo_q;
  logic [CNT_W-1:0] win_hi_q;

  assign ii_len = (AW+1)'(ii_m1) + (AW+1)'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_lo_q <= '0;
      win_hi_q <= '0;
    end else if (start) begin
      win_lo_q <= CNT_W'(cfg_start);
      win_hi_q <= CNT_W'(cfg_start) + CNT_W'(cfg_iters) * CNT_W'(ii_len);
    end
  end

  assign expired = (cyc >= win_hi_q);
  assign fire    = running && (cyc >= win_lo_q) && !expired;
endmodule

// File: rtl/mod_ctx_seq.sv
module mod_ctx_seq
  import mcs_pkg::*;
#(
  parameter int SLOTS     = 16,
  parameter int CTX_W     = 32,
  parameter int NUM_UNITS = 4,
  parameter int CYC_W     = 8,
  parameter int ITER_W    = 6,
  localparam int AW       = $clog2(SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [AW-1:0]               ii_m1,
  input  logic [NUM_UNITS*CYC_W-1:0]  sched_start,
  input  logic [NUM_UNITS*ITER_W-1:0] sched_iters,
  input  logic                        ld_valid,
  output logic                        ld_ready,
  input  logic [AW-1:0]               ld_addr,
  input  logic [CTX_W-1:0]            ld_data,
  output logic [CTX_W-1:0]            ctx_out,
  output logic [AW-1:0]               ctx_slot,
  output logic [NUM_UNITS-1:0]        fire,
  output logic                        running,
  output logic                        done,
  output logic                        load_err
);
  localparam int CNT_W = cnt_bits(CYC_W, ITER_W, AW);

  logic [CNT_W-1:0]     cyc;
  logic [AW-1:0]        ii_q;
  logic [NUM_UNITS-1:0] unit_expired;
  logic                 store_we;

  assign ld_ready = 1'b1;
  assign store_we = ld_valid && !running;

  mcs_ctx_store #(.SLOTS(SLOTS), .CTX_W(CTX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_we),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .rd_addr (ctx_slot),
    .rd_data (ctx_out)
  );

  mcs_run_ctrl #(.AW(AW), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .ii_m1       (ii_m1),
    .all_expired (&unit_expired),
    .running     (running),
    .done        (done),
    .slot        (ctx_slot),
    .cyc         (cyc),
    .ii_q        (ii_q)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    mcs_fire_unit #(.AW(AW), .CYC_W(CYC_W), .ITER_W(ITER_W), .CNT_W(CNT_W)) u_fire (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ii_m1     (ii_m1),
      .cfg_start (sched_start[u*CYC_W +: CYC_W]),
      .cfg_iters (sched_iters[u*ITER_W +: ITER_W]),
      .running   (running),
      .cyc       (cyc),
      .fire      (fire[u]),
      .expired   (unit_expired[u])
    );
  end

  // Error flag: a start pulse clears it and takes precedence over a same-cycle busy load.
  always_ff @(posedge clk) begin
    if (!rst_n)                    load_err <= 1'b0;
    else if (start)                load_err <= 1'b0;
    else if (ld_valid && running)  load_err <= 1'b1;
  end
endmodule

// File: rtl/mod_ctx_seq_chk.sv
module mod_ctx_seq_chk #(
  parameter int NUM_UNITS = 4,
  parameter int AW        = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 ld_valid,
  input logic                 running,
  input logic                 done,
  input logic                 load_err,
  input logic [NUM_UNITS-1:0] fire,
  input logic [AW-1:0]        ctx_slot,
  input logic [AW-1:0]        ii_q
);
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && ctx_slot == '0 && !done));

  a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> ctx_slot <= ii_q);

  a_r3_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start && ctx_slot != ii_q) |=> (!running || ctx_slot == $past(ctx_slot) + 1'b1));

  a_r3_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start && ctx_slot == ii_q) |=> ctx_slot == '0);

  a_r6_idle_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> fire == '0);

  a_r6_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && running));

  a_r7_busy_load_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (running && ld_valid && !start) |=> load_err);
endmodule

bind mod_ctx_seq mod_ctx_seq_chk #(.NUM_UNITS(NUM_UNITS), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .ld_valid (ld_valid),
  .running  (running),
  .done     (done),
  .load_err (load_err),
  .fire     (fire),
  .ctx_slot (ctx_slot),
  .ii_q     (ii_q)
);

// File: tb/test_mod_ctx_seq.sv
module test_mod_ctx_seq;
  localparam int SLOTS = 16;
  localparam int CTX_W = 32;
  localparam int NU    = 4;
  localparam int CYC_W = 8;
  localparam int ITW   = 6;
  localparam int AW    = 4;
  localparam int NV    = 5;
  // Each row: ii_m1, start0..3, iters0..3
  localparam int VT [NV][9] = '{
    '{3,  0, 2, 5, 1,  2, 1, 3, 0},
    '{0,  0, 3, 3, 10, 4, 1, 2, 5},
    '{15, 0, 4, 20, 1, 1, 2, 1, 1},
    '{2,  7, 0, 0, 0,  3, 1, 0, 2},
    '{6,  1, 1, 1, 1,  1, 1, 1, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] ii_m1 = '0;
  logic [NU*CYC_W-1:0] sched_start = '0;
  logic [NU*ITW-1:0] sched_iters = '0;
  logic ld_valid = 1'b0;
  logic ld_ready;
  logic [AW-1:0] ld_addr = '0;
  logic [CTX_W-1:0] ld_data = '0;
  logic [CTX_W-1:0] ctx_out;
  logic [AW-1:0] ctx_slot;
  logic [NU-1:0] fire;
  logic running, done, load_err;

  int nvec = 0;
  int nmis = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mod_ctx_seq i_mod_ctx_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ii_m1(ii_m1),
    .sched_start(sched_start), .sched_iters(sched_iters),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .ctx_out(ctx_out), .ctx_slot(ctx_slot), .fire(fire),
    .running(running), .done(done), .load_err(load_err)
  );

  function automatic logic [CTX_W-1:0] pat(input int v, input int i);
    return 32'hA500_0000 ^ (32'(v) * 32'h0101_0101) ^ (32'(i) * 32'h0010_0013);
  endfunction

  function automatic logic [NU-1:0] exp_fire(input int v, input int k);
    logic [NU-1:0] f;
    int ii;
    ii = VT[v][0] + 1;
    for (int u = 0; u < NU; u++)
      f[u] = (k >= VT[v][1+u]) && (k < VT[v][1+u] + VT[v][5+u] * ii);
    return f;
  endfunction

  function automatic int last_end(input int v);
    int e;
    e = 0;
    for (int u = 0; u < NU; u++)
      if (VT[v][1+u] + VT[v][5+u] * (VT[v][0] + 1) > e)
        e = VT[v][1+u] + VT[v][5+u] * (VT[v][0] + 1);
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nmis++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic load_slot(input int a, input logic [CTX_W-1:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = AW'(a); ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  // Pulse start with the schedule of row v; returns in the k = 0 sample window.
  task automatic pulse_start(input int v);
    @(negedge clk);
    ii_m1 = AW'(VT[v][0]);
    for (int u = 0; u < NU; u++) begin
      sched_start[u*CYC_W +: CYC_W] = CYC_W'(VT[v][1+u]);
      sched_iters[u*ITW +: ITW]     = ITW'(VT[v][5+u]);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nmis++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
  end

  initial begin
    int e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state, R1 ready
    chk(!running && !done && !load_err, "R8 idle flags", {running, done, load_err}, 0);
    chk(fire == '0, "R8 fire", fire, 0);
    chk(ctx_slot == '0 && ctx_out == '0, "R8 slot/ctx", ctx_out, 0);
    chk(ld_ready == 1'b1, "R1 ready", ld_ready, 1);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < SLOTS; i++) load_slot(i, pat(v, i));
      chk(ctx_out == pat(v, 0), "R1 load visible", ctx_out, pat(v, 0));
      e = last_end(v);
      pulse_start(v);
      for (int k = 0; k <= e; k++) begin
        int s;
        s = k % (VT[v][0] + 1);
        chk(running && !done, "R2/R6 running", {running, done}, 2'b10);
        chk(ctx_slot == AW'(s), "R3 slot", ctx_slot, s);
        chk(ctx_out == pat(v, s), "R4 ctx", ctx_out, pat(v, s));
        chk(fire == exp_fire(v, k), "R5 fire", fire, exp_fire(v, k));
        @(negedge clk);
      end
      chk(!running && done, "R6 done", {running, done}, 2'b01);
      chk(fire == '0, "R6 fire idle", fire, 0);
    end

    // R6 done holds
    repeat (3) @(negedge clk);
    chk(done && !running && fire == '0, "R6 done holds", {done, running, fire}, 6'b100000);

    // R7 busy load ignored, flag set; memory holds row 4 contexts
    pulse_start(4);
    chk(!load_err, "R7 err clear", load_err, 0);
    ld_valid = 1'b1; ld_addr = '0; ld_data = 32'hDEAD_BEEF;
    @(negedge clk);
    ld_valid = 1'b0;
    chk(load_err, "R7 err set", load_err, 1);
    while (running) @(negedge clk);
    chk(ctx_slot == '0 && ctx_out == pat(4, 0), "R7 memory unchanged", ctx_out, pat(4, 0));
    chk(load_err, "R7 err sticky", load_err, 1);

    // R2 restart mid-run
    pulse_start(0);
    chk(!load_err, "R7 cleared by start", load_err, 0);
    repeat (6) @(negedge clk);
    pulse_start(0);
    chk(running && ctx_slot == '0, "R2 restart slot", ctx_slot, 0);
    chk(fire == exp_fire(0, 0), "R2 restart fire k0", fire, exp_fire(0, 0));
    @(negedge clk);
    @(negedge clk);
    chk(fire == exp_fire(0, 2) && ctx_slot == AW'(2), "R2 restart k2", {fire, ctx_slot}, {exp_fire(0, 2), 4'd2});

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule